// File: doc/BRIEF.md
# Saturating Integer ALU with Sticky Status Flags

This unit evaluates one 32-bit arithmetic operation per cycle and clamps the answer to the range of the chosen number format instead of letting it wrap. Seven operation kinds are offered: add, subtract, multiply, multiply-accumulate, multiply-decrement, absolute difference and arithmetic shift. Add, subtract, multiply, multiply-accumulate and multiply-decrement come in signed and unsigned forms. Every kind is first computed without loss in a 66-bit signed intermediate value, and only that final value is clamped.

The result is combinational and follows the inputs in the same cycle. Four status bits are held in registers:
- `ovf` marks that the last committed operation clamped.
- `adv_ovf` is the XOR of bits 31 and 30 of the unclamped value, an early warning that the value is leaving the signed range.
- `ovf_sticky` and `adv_sticky` accumulate `ovf` and `adv_ovf` across operations.

A commit strobe decides whether the current operation updates the flags. A clear strobe empties the two sticky bits.

The block has no state machine. Its only storage is the four flag registers.

Top module: `sat_alu`

## Requirements
- R1: In signed form, a true result above 2^31-1 gives 0x7FFFFFFF and a true result below -2^31 gives 0x80000000. A committed clamp of either kind sets `ovf` and `ovf_sticky` on the next clock edge.
- R2: In unsigned form, a true result above 2^32-1 gives 0xFFFFFFFF and a negative true result gives 0x00000000. A committed clamp of either kind sets `ovf` and `ovf_sticky`.
- R3: A committed operation that does not clamp returns the true result, clears `ovf` and leaves `ovf_sticky` unchanged.
- R4: On every commit, `adv_ovf` takes bit 31 XOR bit 30 of the unclamped result, and `adv_sticky` ORs that value in.
- R5: Signed forms sign-extend all operands and unsigned forms zero-extend them. An unsigned subtract whose subtrahend is larger therefore gives 0.
- R6: Multiply-accumulate gives `op_b + op_a*op_c` and multiply-decrement gives `op_b - op_a*op_c`. Each is clamped once, on the final value, so an oversized product that the add brings back into range does not clamp.
- R7: The shift takes `op_b[5:0]` as a signed count and ignores `op_b[31:6]`. A count of 0..31 shifts `op_a` left. A count of -1..-32 shifts `op_a` right arithmetically by the magnitude. The shifted value is then clamped as signed.
- R8: Absolute difference returns `op_a - op_b` if `op_a > op_b` (signed) and `op_b - op_a` otherwise, clamped as signed.
- R9: With `commit` low, the `result` output still follows the inputs, and `ovf` and `adv_ovf` hold their values. With `commit` and `clr_sticky` both low, all four flags hold.
- R10: `clr_sticky` zeroes `ovf_sticky` and `adv_sticky` and does not affect `ovf` or `adv_ovf`. When a commit occurs in the same cycle, its new flag values are ORed into the cleared sticky bits.
- R11: A synchronous active-high `rst` zeroes all four flags.
- R12: `opcode[2:0]` selects the kind, and `opcode[3]=1` selects unsigned form. The kind codes are:
  - 0: add
  - 1: subtract
  - 2: multiply
  - 3: multiply-accumulate
  - 4: multiply-decrement
  - 5: absolute difference, always signed
  - 6: shift, always signed
  - 7: add

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Bits 2:0 select the kind; bit 3 selects unsigned form |
| op_a | input | 32 | First operand (multiplier, shift source) |
| op_b | input | 32 | Second operand (addend, shift count) |
| op_c | input | 32 | Third operand (multiplicand of the accumulate forms) |
| commit | input | 1 | Applies this cycle's flag updates |
| clr_sticky | input | 1 | Zeroes both sticky flags |
| result | output | 32 | Clamped result, combinational |
| ovf | output | 1 | Last committed operation clamped |
| ovf_sticky | output | 1 | Accumulated clamp indication |
| adv_ovf | output | 1 | Bit 31 XOR bit 30 of the last committed unclamped value |
| adv_sticky | output | 1 | Accumulated advance indication |

## Verification
The hardest case to reach is a large intermediate value that must not clamp. In the unsigned multiply-accumulate, the sum is near 2^64. In a multiply-decrement, the product lies outside the 32-bit range but the final difference lies inside it. Both cases expose any datapath that wraps or clamps too early, and neither appears often under random operands. The stimulus drives these operand pairs directly: 0xFFFFFFFF on all three operands, and a product of exactly 2^31 subtracted from 0x7FFFFFFF. It also drives shift counts of +31 and -32, and counts with junk in the upper bits. A random phase then draws operands from a pool of corner values, mixed with random words, random commits and occasional sticky clears.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    // Operation kind carried in opcode[2:0]
    typedef enum logic [2:0] {
        K_ADD  = 3'd0,
        K_SUB  = 3'd1,
        K_MUL  = 3'd2,
        K_MACC = 3'd3,
        K_MDEC = 3'd4,
        K_ABSD = 3'd5,
        K_SHA  = 3'd6,
        K_ADD7 = 3'd7
    } kind_e;

endpackage

// File: rtl/sat_alu_core.sv
module sat_alu_core
    import sat_alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  kind_e                      kind,
    input  logic                       uns,
    input  logic [DW-1:0]              a,
    input  logic [DW-1:0]              b,
    input  logic [DW-1:0]              c,
    output logic signed [2*DW+1:0]     wide,
    output logic                       uns_eff
);
    localparam int XW   = 2*DW + 2;
    localparam int PADW = XW - DW;
    localparam int SHW  = $clog2(DW) + 1;

    logic signed [XW-1:0]  ax, bx, cx;
    logic signed [XW-1:0]  prod_ab, prod_ac;
    logic signed [SHW-1:0] cnt;
    logic [SHW-1:0]        amt;

    // Shift and absolute difference exist in signed form only
    always_comb begin
        uns_eff = uns && (kind != K_ABSD) && (kind != K_SHA);
        if (uns_eff) begin
            ax = $signed({{PADW{1'b0}}, a});
            bx = $signed({{PADW{1'b0}}, b});
            cx = $signed({{PADW{1'b0}}, c});
        end else begin
            ax = $signed({{PADW{a[DW-1]}}, a});
            bx = $signed({{PADW{b[DW-1]}}, b});
            cx = $signed({{PADW{c[DW-1]}}, c});
        end
    end

    // Full-precision products: magnitude never exceeds 2^(2*DW)
    always_comb begin
        prod_ab = ax * bx;
        prod_ac = ax * cx;
    end

    // Signed shift count taken from the low bits of b
    always_comb begin
        cnt = $signed(b[SHW-1:0]);
        if (cnt[SHW-1])
            amt = SHW'(-cnt);
        else
            amt = SHW'(cnt);
    end

    always_comb begin
        unique case (kind)
            K_ADD, K_ADD7: wide = ax + bx;
            K_SUB:         wide = ax - bx;
            K_MUL:         wide = prod_ab;
            K_MACC:        wide = bx + prod_ac;
            K_MDEC:        wide = bx - prod_ac;
            K_ABSD:        wide = (ax > bx) ? (ax - bx) : (bx - ax);
            K_SHA: begin
                if (cnt[SHW-1])
                    wide = ax >>> amt;
                else
                    wide = ax <<< amt;
            end
            default:       wide = ax + bx;
        endcase
    end

endmodule

// File: rtl/sat_alu_clamp.sv
module sat_alu_clamp #(
    parameter int DW = 32
) (
    input  logic signed [2*DW+1:0] wide,
    input  logic                   uns_eff,
    output logic [DW-1:0]          res,
    output logic                   clamped,
    output logic                   adv
);
    localparam int XW = 2*DW + 2;

    localparam logic signed [XW-1:0] SMAX = {{(XW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [XW-1:0] SMIN = {{(XW-DW+1){1'b1}}, {(DW-1){1'b0}}};
    localparam logic signed [XW-1:0] UMAX = {{(XW-DW){1'b0}}, {DW{1'b1}}};
    localparam logic signed [XW-1:0] ZERO = '0;

    logic over_hi, over_lo;

    always_comb begin
        if (uns_eff) begin
            over_hi = wide > UMAX;
            over_lo = wide < ZERO;
        end else begin
            over_hi = wide > SMAX;
            over_lo = wide < SMIN;
        end
        clamped = over_hi | over_lo;
    end

    always_comb begin
        if (over_hi)
            res = uns_eff ? {DW{1'b1}} : {1'b0, {(DW-1){1'b1}}};
        else if (over_lo)
            res = uns_eff ? {DW{1'b0}} : {1'b1, {(DW-1){1'b0}}};
        else
            res = wide[DW-1:0];
    end

    // Advance indication from the two top bits of the signed word
    always_comb adv = wide[DW-1] ^ wide[DW-2];

endmodule

// File: rtl/sat_alu_flags.sv
module sat_alu_flags (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic clr_sticky,
    input  logic clamped,
    input  logic adv_in,
    output logic ovf,
    output logic ovf_sticky,
    output logic adv_ovf,
    output logic adv_sticky
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf        <= 1'b0;
            ovf_sticky <= 1'b0;
            adv_ovf    <= 1'b0;
            adv_sticky <= 1'b0;
        end else begin
            if (commit) begin
                ovf     <= clamped;
                adv_ovf <= adv_in;
            end
            ovf_sticky <= (clr_sticky ? 1'b0 : ovf_sticky) | (commit & clamped);
            adv_sticky <= (clr_sticky ? 1'b0 : adv_sticky) | (commit & adv_in);
        end
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (!ovf && !ovf_sticky && !adv_ovf && !adv_sticky)); // R11

    AST_CLAMP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (commit && clamped) |=> (ovf && ovf_sticky)); // R1

    AST_NO_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (commit && !clamped && !clr_sticky) |=> (!ovf && ovf_sticky == $past(ovf_sticky))); // R3

    AST_ADV_TRACK: assert property (@(posedge clk) disable iff (rst)
        commit |=> (adv_ovf == $past(adv_in) && (adv_sticky || !$past(adv_in)))); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!commit && !clr_sticky) |=> ($stable(ovf) && $stable(adv_ovf)
                                      && $stable(ovf_sticky) && $stable(adv_sticky))); // R9

    AST_CLEAR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (clr_sticky && !commit) |=> (!ovf_sticky && !adv_sticky
                                     && $stable(ovf) && $stable(adv_ovf))); // R10

endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    opcode,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [DW-1:0] op_c,
    input  logic          commit,
    input  logic          clr_sticky,
    output logic [DW-1:0] result,
    output logic          ovf,
    output logic          ovf_sticky,
    output logic          adv_ovf,
    output logic          adv_sticky
);
    localparam int XW = 2*DW + 2;

    kind_e                kind;
    logic signed [XW-1:0] wide;
    logic                 uns_eff;
    logic                 clamped;
    logic                 adv;

    always_comb kind = kind_e'(opcode[2:0]);

    sat_alu_core #(.DW(DW)) u_core (
        .kind    (kind),
        .uns     (opcode[3]),
        .a       (op_a),
        .b       (op_b),
        .c       (op_c),
        .wide    (wide),
        .uns_eff (uns_eff)
    );

    sat_alu_clamp #(.DW(DW)) u_clamp (
        .wide    (wide),
        .uns_eff (uns_eff),
        .res     (result),
        .clamped (clamped),
        .adv     (adv)
    );

    sat_alu_flags u_flags (
        .clk        (clk),
        .rst        (rst),
        .commit     (commit),
        .clr_sticky (clr_sticky),
        .clamped    (clamped),
        .adv_in     (adv),
        .ovf        (ovf),
        .ovf_sticky (ovf_sticky),
        .adv_ovf    (adv_ovf),
        .adv_sticky (adv_sticky)
    );

    // A clamped output must be one of the format's limits
    AST_SIGNED_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (clamped && !uns_eff) |-> (result == {1'b0, {(DW-1){1'b1}}}
                                   || result == {1'b1, {(DW-1){1'b0}}})); // R1

    AST_UNSIGNED_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (clamped && uns_eff) |-> (result == {DW{1'b1}} || result == {DW{1'b0}})); // R2

    AST_SIGNED_ONLY_KINDS: assert property (@(posedge clk) disable iff (rst)
        (opcode[2:0] == 3'd5 || opcode[2:0] == 3'd6) |-> !uns_eff); // R12

endmodule

// File: tb/sim_sat_alu.sv
module sim_sat_alu;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  opcode;
    logic [31:0] op_a, op_b, op_c;
    logic        commit, clr_sticky;
    logic [31:0] result;
    logic        ovf, ovf_sticky, adv_ovf, adv_sticky;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // Behavioural flag model
    bit m_ovf, m_sov, m_adv, m_sadv;

    always #4 clk = ~clk;

    sat_alu u0 (
        .clk(clk), .rst(rst), .opcode(opcode), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .commit(commit), .clr_sticky(clr_sticky), .result(result),
        .ovf(ovf), .ovf_sticky(ovf_sticky), .adv_ovf(adv_ovf), .adv_sticky(adv_sticky)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Exact integer reference in 80 bits
    function automatic logic signed [79:0] ref_val(input int k, input bit u,
                                                   input logic [31:0] a, b, c);
        logic signed [79:0] x, y, z;
        bit su;
        int n;
        su = u && k != 5 && k != 6;
        x = su ? $signed({48'd0, a}) : $signed({{48{a[31]}}, a});
        y = su ? $signed({48'd0, b}) : $signed({{48{b[31]}}, b});
        z = su ? $signed({48'd0, c}) : $signed({{48{c[31]}}, c});
        case (k)
            1: return x - y;
            2: return x * y;
            3: return y + x * z;
            4: return y - x * z;
            5: return (x > y) ? x - y : y - x;
            6: begin
                n = int'($signed(b[5:0]));
                if (n >= 0) return x <<< n;
                else        return x >>> (-n);
            end
            default: return x + y;
        endcase
    endfunction

    task automatic step(input int k, input bit u, input logic [31:0] a, b, c,
                        input bit we, input bit clr, input string tag);
        logic signed [79:0] w;
        logic [31:0] exp_res;
        bit su, clp, av;
        @(negedge clk);
        opcode = {u, 3'(k)}; op_a = a; op_b = b; op_c = c;
        commit = we; clr_sticky = clr;
        #1;
        su = u && k != 5 && k != 6;
        w  = ref_val(k, u, a, b, c);
        clp = 1'b0;
        if (su) begin
            if (w > 80'sh0FFFFFFFF)       begin exp_res = 32'hFFFFFFFF; clp = 1'b1; end
            else if (w < 0)               begin exp_res = 32'h0;        clp = 1'b1; end
            else                          exp_res = w[31:0];
        end else begin
            if (w > 80'sh07FFFFFFF)       begin exp_res = 32'h7FFFFFFF; clp = 1'b1; end
            else if (w < -80'sh080000000) begin exp_res = 32'h80000000; clp = 1'b1; end
            else                          exp_res = w[31:0];
        end
        av = w[31] ^ w[30];
        chk({tag, " result"}, result, exp_res);
        if (we) begin m_ovf = clp; m_adv = av; end
        m_sov  = (clr ? 1'b0 : m_sov)  | (we & clp);
        m_sadv = (clr ? 1'b0 : m_sadv) | (we & av);
        @(posedge clk);
        #1;
        chk({tag, " flags"}, {28'd0, ovf, ovf_sticky, adv_ovf, adv_sticky},
            {28'd0, m_ovf, m_sov, m_adv, m_sadv});
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 8)
            0: return 32'h7FFFFFFF;
            1: return 32'h80000000;
            2: return 32'h00000000;
            3: return 32'hFFFFFFFF;
            4: return 32'h00000001;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        rst = 1'b1; opcode = '0; op_a = '0; op_b = '0; op_c = '0;
        commit = 1'b0; clr_sticky = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset flags", {28'd0, ovf, ovf_sticky, adv_ovf, adv_sticky}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // Signed limits
        step(0, 0, 32'h7FFFFFFF, 32'h00000001, 0, 1, 0, "R1 add hi");
        step(0, 0, 32'h80000000, 32'hFFFFFFFF, 0, 1, 0, "R1 add lo");
        step(1, 0, 32'h00000005, 32'h00000003, 0, 1, 0, "R3 sub fits");
        step(2, 0, 32'h80000000, 32'h80000000, 0, 1, 0, "R1 mul hi");
        // Unsigned limits and extension
        step(0, 1, 32'hFFFFFFFF, 32'h00000001, 0, 1, 0, "R2 uadd hi");
        step(1, 1, 32'h00000000, 32'h00000001, 0, 1, 0, "R5 usub neg");
        step(1, 0, 32'h00000000, 32'h00000001, 0, 1, 0, "R5 ssub fits");
        step(2, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 1, 0, "R2 umul");
        step(0, 1, 32'h40000000, 32'h00000001, 0, 1, 0, "R4 adv bits");
        // Accumulate forms
        step(3, 1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1, 0, "R6 umacc");
        step(4, 0, 32'h00000002, 32'h00000005, 32'h00000003, 1, 0, "R6 mdec");
        step(4, 0, 32'h00010000, 32'h7FFFFFFF, 32'h00008000, 1, 0, "R6 single clamp");
        step(4, 1, 32'h00000002, 32'h00000001, 32'h00000003, 1, 0, "R6 umdec neg");
        // Absolute difference
        step(5, 0, 32'hFFFFFFFB, 32'h0000000A, 0, 1, 0, "R8 absdif");
        step(5, 1, 32'h7FFFFFFF, 32'h80000000, 0, 1, 0, "R8 absdif clamp");
        // Shift
        step(6, 0, 32'h00000001, 32'h0000001F, 0, 1, 0, "R7 shl 31");
        step(6, 0, 32'h80000000, 32'h0000003F, 0, 1, 0, "R7 shr 1");
        step(6, 0, 32'h80000000, 32'h00000020, 0, 1, 0, "R7 shr 32");
        step(6, 0, 32'h00000003, 32'hFFFFFF41, 0, 1, 0, "R7 count junk");
        step(7, 1, 32'hFFFFFFFF, 32'h00000002, 0, 1, 0, "R12 kind7 add");
        // Commit gating and sticky clear
        step(0, 0, 32'h00000001, 32'h00000001, 0, 1, 0, "R3 clear ovf");
        step(0, 0, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, 0, "R9 no commit");
        step(0, 0, 32'h00000001, 32'h00000001, 0, 0, 1, "R10 clear only");
        step(0, 0, 32'h7FFFFFFF, 32'h00000001, 0, 1, 0, "R1 set again");
        step(0, 0, 32'h00000001, 32'h00000002, 0, 0, 1, "R10 clear keep ovf");
        step(0, 0, 32'h7FFFFFFF, 32'h00000001, 0, 1, 1, "R10 clear with commit");

        for (int i = 0; i < 400; i++) begin
            step($urandom % 8, $urandom % 2, pick(), pick(), pick(),
                 ($urandom % 4) != 0, ($urandom % 8) == 0, "R12 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule